// File: doc/BRIEF.md
# Priority Flag Index Encoder

The block takes a wide vector of one-bit match flags, one per rule, and reports which flag is set as a binary number. When more than one flag is set in the same cycle, the flag with the largest number wins. A separate hit output tells an index of zero caused by flag 0 apart from the case where no flag is set. Both outputs are registered, so the result for the flags sampled at one rising clock edge appears just after that edge.

The encoder is built as a binary OR tree over the flags. Each output bit is formed from the ORs of the upper children at one tree level. Each of those terms is masked by the complements of the upper branches above it. An OR node is left out when no output bit reads it: the root and the lowest node of every level are never built. When the flag count is not a power of two, the vector is widened with constant-zero flags up to the next power of two.

Top module: `prio_tree_enc`

## Requirements
- R1: One clock edge after the flags are sampled, `idx_o` holds the number of the highest-numbered set flag, where flag i is `flags_i[i]`. No set flag has a higher number than the reported index.
- R2: `hit_o` is 1 exactly when at least one flag was set at the previous sampling edge, and 0 otherwise.
- R3: The most significant bit of `idx_o` equals the OR of the upper half of the flags after padding to a power of two. The lower half of the flags does not affect that bit.
- R4: When no flag is set, both `hit_o` and `idx_o` read 0 after the next edge.
- R5: When only flag 0 is set, `hit_o` reads 1 and `idx_o` reads 0.
- R6: `idx_o` is ceil(log2(N_FLAGS)) bits wide: 4 bits for 16 flags, 6 for 64 and 11 for 1519.
- R7: With a flag count that is not a power of two, the padding flags never win. With 1519 flags, setting flag 1518 alone gives index 1518.
- R8: While `rst_n` is low, `idx_o` and `hit_o` are 0. Asserting `rst_n` clears them without waiting for a clock edge.
- R9: When every flag is set, `idx_o` reads N_FLAGS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| flags_i | input | N_FLAGS | Match flags; bit i is flag i |
| idx_o | output | $clog2(N_FLAGS) | Registered number of the highest set flag |
| hit_o | output | 1 | Registered OR of all flags |

## Verification
The bench walks through all 65536 patterns of a 16-flag encoder. An error in the gating of any branch would make the encoder report a lower flag while a higher one is set, or mix bits from two flags into one index. Random patterns of varying density drive 64-flag and 1519-flag instances. In the padded instance, a padding slot wired wrongly would hide flag 1518 or move the top result. Flag 0 alone is compared with the all-clear pattern: a hit output taken from the index instead of the OR of the flags would read 0 for flag 0. A reset asserted between edges must clear the outputs at once; a reset that only acted on the clock edge would leave the old index visible.

// File: rtl/prio_tree_enc_pkg.sv
`timescale 1ns/1ps
package prio_tree_enc_pkg;

  // Position of tree node (level lvl, column k) in the packed node vector.
  // Column 0 of every level is never built, so a level holds 2**lvl - 1 nodes.
  function automatic int node_pos(input int lvl, input int k);
    return (1 << lvl) - lvl - 2 + k;
  endfunction

  // Position of the upper-child node (lvl, 2*j+1) in the odd-node vector.
  function automatic int odd_pos(input int lvl, input int j);
    return (1 << (lvl - 1)) - 1 + j;
  endfunction

  // Position of the gate of node (lvl, k) for levels 1 .. depth-1.
  function automatic int gate_pos(input int lvl, input int k);
    return (1 << lvl) - 2 + k;
  endfunction

endpackage

// File: rtl/pe_or_tree.sv
`timescale 1ns/1ps
module pe_or_tree
  import prio_tree_enc_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int NODE_CNT = 2 * (1 << IDX_W) - 2 - IDX_W,
  parameter int ODD_CNT  = (1 << IDX_W) - 1
) (
  input  logic [(1<<IDX_W)-1:1] leaf_i,
  output logic [ODD_CNT-1:0]    odd_o
);

  // Pruned tree: the root and column 0 of every level are omitted
  logic [NODE_CNT-1:0] node;

  // leaf level: flag k sits in column k (flag 0 has no tree node)
  for (genvar k = 1; k < (1 << IDX_W); k++) begin : g_leaf
    assign node[node_pos(IDX_W, k)] = leaf_i[k];
  end

  // inner levels: each node ORs its two children
  for (genvar d = 1; d < IDX_W; d++) begin : g_lvl
    for (genvar k = 1; k < (1 << d); k++) begin : g_node
      assign node[node_pos(d, k)] = node[node_pos(d + 1, 2 * k)]
                                  | node[node_pos(d + 1, 2 * k + 1)];
    end
  end

  // hand out only the upper children; the address logic reads nothing else
  for (genvar d = 1; d <= IDX_W; d++) begin : g_out
    for (genvar j = 0; j < (1 << (d - 1)); j++) begin : g_odd
      assign odd_o[odd_pos(d, j)] = node[node_pos(d, 2 * j + 1)];
    end
  end

endmodule

// File: rtl/pe_addr_gen.sv
`timescale 1ns/1ps
module pe_addr_gen
  import prio_tree_enc_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ODD_CNT = (1 << IDX_W) - 1
) (
  input  logic [ODD_CNT-1:0] odd_i,
  output logic [IDX_W-1:0]   addr_o
);

  localparam int GATE_CNT = (IDX_W > 1) ? (1 << IDX_W) - 2 : 1;

  // gate[node] = 1 when no upper branch above that node holds a set flag
  logic [GATE_CNT-1:0] gate;

  if (IDX_W == 1) begin : g_no_gate
    assign gate = '0;
  end

  for (genvar d = 1; d < IDX_W; d++) begin : g_glvl
    for (genvar k = 0; k < (1 << d); k++) begin : g_gnode
      logic up;
      if (d == 1) begin : g_top
        assign up = 1'b1;
      end else begin : g_inner
        assign up = gate[gate_pos(d - 1, k >> 1)];
      end
      if (k % 2 == 1) begin : g_upper
        assign gate[gate_pos(d, k)] = up;
      end else begin : g_lower
        assign gate[gate_pos(d, k)] = up & ~odd_i[odd_pos(d, k / 2)];
      end
    end
  end

  // address bit IDX_W-d: any unmasked upper child on level d
  for (genvar d = 1; d <= IDX_W; d++) begin : g_alvl
    logic [(1<<(d-1))-1:0] term;
    for (genvar j = 0; j < (1 << (d - 1)); j++) begin : g_term
      if (d == 1) begin : g_msb
        assign term[j] = odd_i[odd_pos(d, j)];
      end else begin : g_rest
        assign term[j] = odd_i[odd_pos(d, j)] & gate[gate_pos(d - 1, j)];
      end
    end
    assign addr_o[IDX_W-d] = |term;
  end

endmodule

// File: rtl/pe_out_reg.sv
`timescale 1ns/1ps
module pe_out_reg #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_d,
  input  logic             hit_d,
  output logic [IDX_W-1:0] idx_q,
  output logic             hit_q
);

  logic [IDX_W-1:0] idx_nx;
  logic             hit_nx;

  always_comb begin
    idx_nx = idx_d;
    hit_nx = hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      hit_q <= 1'b0;
    end else begin
      idx_q <= idx_nx;
      hit_q <= hit_nx;
    end
  end

endmodule

// File: rtl/prio_tree_enc.sv
`timescale 1ns/1ps
module prio_tree_enc #(
  parameter int N_FLAGS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_FLAGS-1:0]         flags_i,
  output logic [$clog2(N_FLAGS)-1:0] idx_o,
  output logic                       hit_o
);

  localparam int IDX_W    = $clog2(N_FLAGS);
  localparam int LEAVES   = 1 << IDX_W;
  localparam int NODE_CNT = 2 * LEAVES - 2 - IDX_W;
  localparam int ODD_CNT  = LEAVES - 1;

  logic [LEAVES-1:0]  flags_pad;
  logic [ODD_CNT-1:0] odd_nodes;
  logic [IDX_W-1:0]   addr_c;
  logic               any_c;

  if (LEAVES > N_FLAGS) begin : g_pad
    assign flags_pad = {{(LEAVES - N_FLAGS){1'b0}}, flags_i};
  end else begin : g_nopad
    assign flags_pad = flags_i;
  end

  assign any_c = |flags_pad;

  pe_or_tree #(
    .IDX_W   (IDX_W),
    .NODE_CNT(NODE_CNT),
    .ODD_CNT (ODD_CNT)
  ) u_tree (
    .leaf_i(flags_pad[LEAVES-1:1]),
    .odd_o (odd_nodes)
  );

  pe_addr_gen #(
    .IDX_W  (IDX_W),
    .ODD_CNT(ODD_CNT)
  ) u_addr (
    .odd_i (odd_nodes),
    .addr_o(addr_c)
  );

  pe_out_reg #(
    .IDX_W(IDX_W)
  ) u_oreg (
    .clk  (clk),
    .rst_n(rst_n),
    .idx_d(addr_c),
    .hit_d(any_c),
    .idx_q(idx_o),
    .hit_q(hit_o)
  );

  AST_IDX_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((($past(flags_i) >> idx_o) & {{(N_FLAGS-1){1'b0}}, 1'b1}) != '0)); // R1
  AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((($past(flags_i) >> idx_o) >> 1) == '0)); // R1
  AST_HIT_OR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hit_o == ($past(flags_i) != '0))); // R2
  AST_MSB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    addr_c[IDX_W-1] == (|flags_pad[LEAVES-1:LEAVES/2])); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (idx_o == '0)); // R4

endmodule

// File: tb/prio_tree_enc_test.sv
`timescale 1ns/1ps
module prio_tree_enc_test;

  logic          clk;
  logic          rst_n;
  logic [15:0]   f16;
  logic [63:0]   f64;
  logic [1518:0] f1519;
  logic [3:0]    idx16;
  logic [5:0]    idx64;
  logic [10:0]   idx1519;
  logic          hit16, hit64, hit1519;

  int total_cnt = 0;
  int fail_cnt  = 0;
  bit done      = 1'b0;

  prio_tree_enc #(.N_FLAGS(16)) uut (
    .clk(clk), .rst_n(rst_n), .flags_i(f16), .idx_o(idx16), .hit_o(hit16));
  prio_tree_enc #(.N_FLAGS(64)) uut64 (
    .clk(clk), .rst_n(rst_n), .flags_i(f64), .idx_o(idx64), .hit_o(hit64));
  prio_tree_enc #(.N_FLAGS(1519)) uut1519 (
    .clk(clk), .rst_n(rst_n), .flags_i(f1519), .idx_o(idx1519), .hit_o(hit1519));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural model: highest set bit among the lowest n bits, -1 if none
  function automatic int top_bit(input logic [2047:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total_cnt++;
    if (act != exp) begin
      fail_cnt++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req, input int act_idx, input logic act_hit,
                            input int e);
    check(req, act_idx, (e < 0) ? 0 : e);
    check("R2", int'(act_hit), (e >= 0) ? 1 : 0);
  endtask

  // drive at the falling edge, result is registered at the next rising edge
  task automatic step(input logic [15:0] a, input logic [63:0] b,
                      input logic [1518:0] c, input string req);
    logic [2047:0] w;
    @(negedge clk);
    f16 = a; f64 = b; f1519 = c;
    @(posedge clk);
    #1;
    w = '0; w[15:0] = a;
    check_pair(req, int'(idx16), hit16, top_bit(w, 16));
    check("R3", int'(idx16[3]), int'(|a[15:8]));
    w = '0; w[63:0] = b;
    check_pair(req, int'(idx64), hit64, top_bit(w, 64));
    check("R3", int'(idx64[5]), int'(|b[63:32]));
    w = '0; w[1518:0] = c;
    check_pair(req, int'(idx1519), hit1519, top_bit(w, 1519));
    check("R3", int'(idx1519[10]), int'(|c[1518:1024]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      total_cnt++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
      $finish;
    end
  end

  initial begin
    logic [1518:0] c;
    rst_n = 1'b0;
    f16 = '1; f64 = '1; f1519 = '1;
    repeat (3) @(posedge clk);
    #1;
    // R8: held in reset with all flags set
    check("R8", int'(idx16), 0);   check("R8", int'(hit16), 0);
    check("R8", int'(idx64), 0);   check("R8", int'(hit64), 0);
    check("R8", int'(idx1519), 0); check("R8", int'(hit1519), 0);
    // R6: index widths
    check("R6", $bits(uut.idx_o), 4);
    check("R6", $bits(uut64.idx_o), 6);
    check("R6", $bits(uut1519.idx_o), 11);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: nothing set
    step('0, '0, '0, "R4");
    // R5: only flag 0
    c = '0; c[0] = 1'b1;
    step(16'h0001, 64'h1, c, "R5");
    check("R5", int'(hit1519), 1);
    // R9: every flag set
    step('1, '1, '1, "R9");
    check("R9", int'(idx1519), 1518);
    // R7: top real flag of the padded instance, alone and with flag 0
    c = '0; c[1518] = 1'b1;
    step(16'h8000, 64'h8000_0000_0000_0000, c, "R7");
    check("R7", int'(idx1519), 1518);
    c[0] = 1'b1;
    step(16'h8001, 64'h8000_0000_0000_0001, c, "R7");
    // R3: lower half full, upper half empty, then one upper bit
    c = '0; c[1023:0] = '1;
    step(16'h00FF, 64'h0000_0000_FFFF_FFFF, c, "R3");
    c[1024] = 1'b1;
    step(16'h01FF, 64'h0000_0001_FFFF_FFFF, c, "R3");

    // R8: reset asserted between edges clears outputs at once
    step('1, '1, '1, "R1");
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R8", int'(idx16), 0);   check("R8", int'(hit16), 0);
    check("R8", int'(idx64), 0);   check("R8", int'(hit64), 0);
    check("R8", int'(idx1519), 0); check("R8", int'(hit1519), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every 16-flag pattern
    for (int p = 0; p < 65536; p++) begin
      logic [15:0] a;
      string tag;
      a = p[15:0];
      tag = (a == 16'h0) ? "R4" : (a == 16'h1) ? "R5" : (a == 16'hFFFF) ? "R9" : "R1";
      step(a, {4{a}}, {a, {1503{1'b0}}}, tag);
    end

    // R1 and R7: random patterns of several densities
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] b;
      int dens;
      case ($urandom % 3)
        0:       b = {$urandom, $urandom};
        1:       b = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        default: b = 64'h1 << ($urandom % 64);
      endcase
      case ($urandom % 4)
        0:       dens = 2;
        1:       dens = 50;
        2:       dens = 400;
        default: dens = 5000;
      endcase
      c = '0;
      for (int i = 0; i < 1519; i++) if (($urandom % dens) == 0) c[i] = 1'b1;
      step($urandom, b, c, "R1");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
    $finish;
  end

endmodule